// File: doc/BRIEF.md
# Non-Restoring Sequential Divider

This block divides one unsigned integer by another over several clock cycles and returns the quotient and the remainder. Each cycle yields one quotient bit. A partial remainder that goes negative is never put back; the next cycle adds the divisor instead of subtracting it. One extra cycle at the end adds the divisor back if the final remainder is negative.

A caller loads both operands with a one-cycle start pulse while the block is idle. `busy` stays high while the block works, and `done` pulses for one cycle when the results are ready. The quotient is the low result word and the remainder is the high result word. Both stay on the outputs until the next accepted start. A zero divisor takes a short path: the block raises a flag and returns a fixed answer without iterating.

Top module: `nr_divider`

## Requirements
- R1: After reset, `busy`, `done` and `div_by_zero` are all 0.
- R2: A `start` seen at a clock edge while `busy` is 0, with a nonzero divisor, captures both operands at that edge, and `busy` is 1 from then on.
- R3: For a nonzero divisor, `done` goes to 1 after the W+1-th edge that follows the capture edge (W iterations plus one correction). At that same edge `busy` falls. `done` lasts exactly one cycle.
- R4: With `done` high and a nonzero divisor, `quotient` equals floor(dividend / divisor) and `remainder` equals dividend mod divisor. For example, 11 divided by 3 gives 3 and 2.
- R5: With a nonzero divisor, the `remainder` shown with `done` is always less than the divisor. A negative final partial remainder is corrected by adding the divisor once.
- R6: A zero divisor at an accepted start sets `done` and `div_by_zero` to 1 after that same edge, with `busy` staying 0. `quotient` is all ones and `remainder` equals the dividend.
- R7: A `start` while `busy` is 1 is ignored. The running division keeps its operands, and its completion time does not change.
- R8: After `done`, `quotient`, `remainder` and `div_by_zero` hold their values until the next accepted start.
- R9: `busy` and `done` are never 1 together. `div_by_zero` returns to 0 when a start with a nonzero divisor is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request; operands are taken when idle |
| dividend | input | W | Unsigned dividend |
| divisor | input | W | Unsigned divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse: results valid |
| div_by_zero | output | 1 | Last accepted request had a zero divisor |
| quotient | output | W | Quotient (low result word) |
| remainder | output | W | Remainder (high result word) |

## Verification
The bench builds the divider with W = 8. At that width every divisor value from 0 to 255 can be swept against the extreme dividends (0, 1, 127, 128, 200, 255) in a short run. This reaches each case where the final partial remainder is negative and needs the correction, the divide-by-one and divide-by-self edges, and the zero-divisor path. Random operand pairs, back-to-back starts on the cycle after `done`, and starts issued mid-division fill in the rest. A behavioural model that uses integer division is compared against the outputs on every cycle.

// File: rtl/nr_divider.sv
module nr_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic         div_by_zero,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  localparam int CW = $clog2(W + 1);

  logic [W:0]    part;
  logic [W-1:0]  qacc;
  logic [W-1:0]  dsr;
  logic [CW-1:0] steps;

  wire [W:0] dsr_x   = {1'b0, dsr};
  wire [W:0] shifted = {part[W-1:0], qacc[W-1]};
  wire [W:0] stepped = part[W] ? shifted + dsr_x : shifted - dsr_x;

  assign quotient  = qacc;
  assign remainder = part[W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      part        <= '0;
      qacc        <= '0;
      dsr         <= '0;
      steps       <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
      div_by_zero <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          dsr <= divisor;
          if (divisor == '0) begin
            qacc        <= '1;
            part        <= {1'b0, dividend};
            div_by_zero <= 1'b1;
            done        <= 1'b1;
          end else begin
            qacc        <= dividend;
            part        <= '0;
            div_by_zero <= 1'b0;
            steps       <= CW'(W);
            busy        <= 1'b1;
          end
        end
      end else if (steps != '0) begin
        part  <= stepped;
        qacc  <= {qacc[W-2:0], ~stepped[W]};
        steps <= steps - CW'(1);
      end else begin
        if (part[W]) part <= part + dsr_x;
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_falls_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_rem_below_divisor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_by_zero) |-> (remainder < dsr));
  assert_zero_div_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_by_zero) |-> (quotient == '1 && !busy));
  assert_busy_done_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  assert_hold_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start && $past(!busy)) |=> ($stable(quotient) && $stable(remainder)));
endmodule

// File: tb/sim_nr_divider.sv
`timescale 1ns/1ps
module sim_nr_divider;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done, div_by_zero;
  logic [W-1:0] quotient, remainder;

  int checks = 0;
  int errors = 0;

  nr_divider #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .div_by_zero(div_by_zero),
    .quotient(quotient), .remainder(remainder)
  );

  always #2.5 clk = ~clk;

  // behavioural reference
  bit busy_m = 0, done_m = 0, z_m = 0, have_res = 0;
  int cnt_m = 0;
  int a_m = 0, b_m = 0, q_m = 0, r_m = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      busy_m = 0; done_m = 0; z_m = 0; cnt_m = 0; have_res = 0;
    end else begin
      done_m = 0;
      if (busy_m) begin
        if (cnt_m == 1) begin
          busy_m = 0; done_m = 1; have_res = 1;
          q_m = a_m / b_m; r_m = a_m % b_m;
        end
        cnt_m--;
      end else if (start) begin
        a_m = int'(dividend); b_m = int'(divisor);
        if (b_m == 0) begin
          done_m = 1; z_m = 1; have_res = 1;
          q_m = (1 << W) - 1; r_m = a_m;
        end else begin
          busy_m = 1; z_m = 0; cnt_m = W + 1; have_res = 0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == busy_m, "R2 R7 busy", int'(busy), int'(busy_m));
      chk(done == done_m, "R3 done", int'(done), int'(done_m));
      chk(div_by_zero == z_m, "R6 R9 div_by_zero", int'(div_by_zero), int'(z_m));
      chk(!(busy && done), "R9 busy/done overlap", int'({busy, done}), 0);
      if (done_m) begin
        chk(int'(quotient) == q_m, z_m ? "R6 quotient" : "R4 quotient", int'(quotient), q_m);
        chk(int'(remainder) == r_m, z_m ? "R6 remainder" : "R4 remainder", int'(remainder), r_m);
        if (!z_m) chk(int'(remainder) < b_m, "R5 remainder below divisor", int'(remainder), b_m);
      end else if (have_res && !busy_m) begin
        chk(int'(quotient) == q_m, "R8 quotient held", int'(quotient), q_m);
        chk(int'(remainder) == r_m, "R8 remainder held", int'(remainder), r_m);
      end
    end
  end

  task automatic run(input int a, input int b);
    @(negedge clk);
    start = 1'b1; dividend = W'(a); divisor = W'(b);
    @(negedge clk);
    start = 1'b0;
    while (busy_m) @(negedge clk);
  endtask

  task automatic finish_up;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !div_by_zero, "R1 reset state", int'({busy, done, div_by_zero}), 0);

    run(11, 3);
    chk(quotient == 3 && remainder == 2, "R4 11/3", int'({quotient, remainder}), int'({8'd3, 8'd2}));
    run(77, 0);
    run(255, 1);
    run(255, 255);
    run(0, 5);
    run(5, 7);

    // R7: start while busy is ignored
    @(negedge clk);
    start = 1'b1; dividend = 8'd200; divisor = 8'd9;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1; dividend = 8'd17; divisor = 8'd0;
    @(negedge clk);
    start = 1'b0;
    while (busy_m) @(negedge clk);
    chk(quotient == 8'd22 && remainder == 8'd2, "R7 first operands kept",
        int'({quotient, remainder}), int'({8'd22, 8'd2}));

    // back-to-back: start on the done cycle
    @(negedge clk);
    start = 1'b1; dividend = 8'd100; divisor = 8'd7;
    @(negedge clk);
    while (!done_m) @(negedge clk);
    dividend = 8'd99; divisor = 8'd10;
    @(negedge clk);
    start = 1'b0;
    while (busy_m) @(negedge clk);

    foreach (dv_list[i]) begin
      for (int b = 0; b < (1 << W); b++) run(dv_list[i], b);
    end
    for (int n = 0; n < 300; n++) run($urandom_range(0, 255), $urandom_range(0, 255));
    repeat (5) @(negedge clk);
    finish_up();
  end

  int dv_list[6] = '{0, 1, 127, 128, 200, 255};
endmodule